// File: doc/BRIEF.md
# Flash Program/Erase Sequencer with Suspend

This block is the internal write engine of a serial NOR flash. A command decoder in front of it hands over single-cycle requests. Each request carries an opcode and a byte address. A page-program request then streams its data bytes through a separate data port. The sequencer works through the target range one byte at a time. For each byte it holds a timed step on the array port, writes at the end of the step, and reads the location back on the next cycle to verify it. A byte that fails verification gets a fresh step, up to a fixed number of tries. When the whole range is done, the operation finishes.

Four status bits are exported:
- a busy flag (write in progress);
- a write-enable latch, which gates every program or erase;
- a suspended flag;
- a verify-failure flag.

An operation in flight can be parked with a suspend request and picked up again with resume. It continues from the byte where it stopped. A command-reset request abandons any operation and returns to idle. The region sizes, step lengths and try limit are parameters, so a bench can shrink the array and the timings.

Top module: `flash_pe_seq`

## Requirements
- R1: After reset all four status bits are 0 and no array write occurs. Opcode 1 (write enable) sets the latch and opcode 2 (write disable) clears it. Both are honoured only while idle or suspended.
- R2: A program or erase request (opcodes 3 to 7) issued while the latch is 0 is ignored: no array write, and the busy flag stays 0.
- R3: Busy reads 1 from the cycle after an accepted program or erase until it completes. On completion the write-enable latch reads 0.
- R4: Opcodes 4, 5, 6 and 7 erase a naturally aligned region of 2^SECT_W, 2^B32_W or 2^B64_W bytes, or the whole array. Every byte in the region becomes 0xFF and bytes outside it are unchanged.
- R5: Opcode 3 (page program) leaves each targeted byte holding its previous value ANDed with the supplied byte.
- R6: Streamed program bytes land at successive offsets from the start offset and wrap inside the 2^PAGE_W-byte page. When more bytes than a page are sent, the later byte wins. Offsets that receive no byte are untouched.
- R7: Each step asserts the array write on its T-th cycle (T_PGM or T_ERS). The read-back takes the next cycle and one selection cycle follows, so consecutive erase writes are T_ERS+2 cycles apart.
- R8: A byte that reads back wrong is written again. After MAX_TRY writes that all fail, the error flag sets and the operation ends with busy 0. The next accepted operation clears the flag.
- R9: Opcode 8 (suspend) during an operation makes busy read 0 and suspended read 1 from the next cycle, and no array write occurs while suspended.
- R10: Opcode 9 (resume) from the suspended state restores busy. The operation completes with the correct contents, repeating at most the one byte that was in flight.
- R11: Opcode 10 (command reset) ends any operation, including a suspended one. Busy, suspended and the latch read 0 on the next cycle, and array writes stop.
- R12: Program and erase requests that arrive while busy or suspended are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | ADDR_W | Target byte address |
| dat_valid | input | 1 | Program data byte strobe |
| dat_byte | input | 8 | Program data byte |
| dat_last | input | 1 | Marks the final data byte |
| mem_addr | output | ADDR_W | Array byte address |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data (combinational) |
| st_wip | output | 1 | Write in progress |
| st_wel | output | 1 | Write-enable latch |
| st_sus | output | 1 | Operation suspended |
| st_err | output | 1 | Verify failure on last operation |

## Verification
A wrong range mask or a wrong cursor shows up as array writes outside the selected region. It also shows up as a byte inside the region that keeps its old value. The array comparison after each operation exposes both, within the operation's own run time. A timer or state fault changes the spacing between write strobes, so the very next pair of writes shows it. A status fault shows up one cycle after the command that should have moved the flags. A suspend that leaks writes, or a resume that restarts from the beginning, shows up as a changed write count while parked or as an excess of writes at completion.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_WREN   = 4'd1,
        OP_WRDI   = 4'd2,
        OP_PGM    = 4'd3,
        OP_SE     = 4'd4,
        OP_BE32   = 4'd5,
        OP_BE64   = 4'd6,
        OP_CE     = 4'd7,
        OP_SUSP   = 4'd8,
        OP_RESUME = 4'd9,
        OP_RST    = 4'd10
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SCAN,
        ST_PULSE,
        ST_VERIFY,
        ST_SUSP
    } st_e;

    typedef struct packed {
        logic wip;
        logic wel;
        logic sus;
        logic err;
    } status_t;

    function automatic logic is_write_op(op_e op);
        return (op == OP_PGM) || (op == OP_SE) || (op == OP_BE32) ||
               (op == OP_BE64) || (op == OP_CE);
    endfunction

    // log2 of the byte span an operation covers
    function automatic int span_width(op_e op, int page_w, int sect_w,
                                      int b32_w, int b64_w, int addr_w);
        case (op)
            OP_PGM:  return page_w;
            OP_SE:   return sect_w;
            OP_BE32: return b32_w;
            OP_BE64: return b64_w;
            default: return addr_w;
        endcase
    endfunction

endpackage

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAGE_W-1:0] start_off,
    input  logic              push,
    input  logic [7:0]        push_byte,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_byte,
    output logic              rd_has
);
    localparam int PAGE = 1 << PAGE_W;

    logic [7:0]        data_q [PAGE];
    logic [PAGE-1:0]   mask_q;
    logic [PAGE_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ptr_q  <= '0;
        end else if (start) begin
            mask_q <= '0;
            ptr_q  <= start_off;
        end else if (push) begin
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !start) data_q[ptr_q] <= push_byte;
    end

    assign rd_byte = data_q[rd_idx];
    assign rd_has  = mask_q[rd_idx];

    // R6: a pushed byte marks its offset as loaded
    p_push_marks_r6: assert property (@(posedge clk) disable iff (rst)
        (push && !start) |=> mask_q[$past(ptr_q)]);

    // R6: the write pointer advances by one per byte, wrapping in the page
    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (push && !start) |=> ptr_q == $past(ptr_q) + 1'b1);

endmodule

// File: rtl/flash_step_timer.sv
module flash_step_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int PAGE_W  = 8,
    parameter int SECT_W  = 12,
    parameter int B32_W   = 15,
    parameter int B64_W   = 16,
    parameter int T_PGM   = 64,
    parameter int T_ERS   = 256,
    parameter int MAX_TRY = 4,
    parameter int CNT_W   = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              dat_valid,
    input  logic              dat_last,
    output logic              buf_start,
    output logic [PAGE_W-1:0] buf_off,
    output logic              buf_push,
    output logic [PAGE_W-1:0] buf_idx,
    input  logic [7:0]        buf_byte,
    input  logic              buf_has,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_zero,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output status_t           status
);
    localparam int TRY_W = $clog2(MAX_TRY + 1);
    localparam logic [ADDR_W-1:0] ONES = '1;

    st_e               st_q;
    logic [ADDR_W-1:0] cur_q, base_q, rmask_q;
    logic              pgm_q, wel_q, err_q;
    logic [7:0]        exp_q;
    logic [TRY_W-1:0]  try_q;

    op_e               op;
    logic              sus_req, rst_req, res_req, start_req;
    logic              last, skip, match, give_up;
    logic [ADDR_W-1:0] new_mask;

    assign op        = op_e'(cmd_op);
    assign sus_req   = cmd_valid && (op == OP_SUSP);
    assign rst_req   = cmd_valid && (op == OP_RST);
    assign res_req   = cmd_valid && (op == OP_RESUME);
    assign start_req = cmd_valid && (st_q == ST_IDLE) && wel_q && is_write_op(op);
    assign new_mask  = ONES >> (ADDR_W - span_width(op, PAGE_W, SECT_W, B32_W, B64_W, ADDR_W));

    assign last    = ((cur_q & rmask_q) == rmask_q);
    assign skip    = pgm_q && !buf_has;
    assign match   = (mem_rdata == exp_q);
    assign give_up = (try_q == TRY_W'(MAX_TRY - 1));

    assign buf_start = start_req && (op == OP_PGM);
    assign buf_off   = cmd_addr[PAGE_W-1:0];
    assign buf_push  = (st_q == ST_LOAD) && dat_valid && !rst_req;
    assign buf_idx   = cur_q[PAGE_W-1:0];

    assign tmr_val  = pgm_q ? CNT_W'(T_PGM - 1) : CNT_W'(T_ERS - 1);
    assign tmr_load = !rst_req && !sus_req &&
                      (((st_q == ST_SCAN) && !skip) ||
                       ((st_q == ST_VERIFY) && !match && !give_up));

    assign mem_addr  = cur_q;
    assign mem_we    = (st_q == ST_PULSE) && tmr_zero && !sus_req && !rst_req;
    assign mem_wdata = pgm_q ? (mem_rdata & buf_byte) : 8'hFF;

    assign status.wip = (st_q == ST_LOAD) || (st_q == ST_SCAN) ||
                        (st_q == ST_PULSE) || (st_q == ST_VERIFY);
    assign status.wel = wel_q;
    assign status.sus = (st_q == ST_SUSP);
    assign status.err = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cur_q   <= '0;
            base_q  <= '0;
            rmask_q <= '0;
            pgm_q   <= 1'b0;
            wel_q   <= 1'b0;
            err_q   <= 1'b0;
            exp_q   <= '0;
            try_q   <= '0;
        end else if (rst_req) begin
            st_q  <= ST_IDLE;
            wel_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cmd_valid && op == OP_WREN) wel_q <= 1'b1;
                    if (cmd_valid && op == OP_WRDI) wel_q <= 1'b0;
                    if (start_req) begin
                        err_q   <= 1'b0;
                        pgm_q   <= (op == OP_PGM);
                        rmask_q <= new_mask;
                        base_q  <= cmd_addr & ~new_mask;
                        cur_q   <= cmd_addr & ~new_mask;
                        st_q    <= (op == OP_PGM) ? ST_LOAD : ST_SCAN;
                    end
                end
                ST_LOAD: begin
                    if (dat_valid && dat_last) st_q <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (sus_req) begin
                        st_q <= ST_SUSP;
                    end else if (skip) begin
                        if (last) begin
                            st_q  <= ST_IDLE;
                            wel_q <= 1'b0;
                        end else begin
                            cur_q <= cur_q + 1'b1;
                        end
                    end else begin
                        try_q <= '0;
                        st_q  <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (sus_req) begin
                        st_q <= ST_SUSP;
                    end else if (tmr_zero) begin
                        exp_q <= mem_wdata;
                        st_q  <= ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (sus_req) begin
                        st_q <= ST_SUSP;
                    end else if (match) begin
                        if (last) begin
                            st_q  <= ST_IDLE;
                            wel_q <= 1'b0;
                        end else begin
                            cur_q <= cur_q + 1'b1;
                            st_q  <= ST_SCAN;
                        end
                    end else if (give_up) begin
                        err_q <= 1'b1;
                        wel_q <= 1'b0;
                        st_q  <= ST_IDLE;
                    end else begin
                        try_q <= try_q + 1'b1;
                        st_q  <= ST_PULSE;
                    end
                end
                ST_SUSP: begin
                    if (cmd_valid && op == OP_WREN) wel_q <= 1'b1;
                    if (cmd_valid && op == OP_WRDI) wel_q <= 1'b0;
                    if (res_req) st_q <= ST_SCAN;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2: the array is never written outside an operation
    p_no_write_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !status.wip |-> !mem_we);

    // R3: busy dropping without a suspend leaves the latch cleared
    p_wel_drop_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(status.wip) && !status.wip && !status.sus) |-> !status.wel);

    // R4: the array address stays within the selected aligned region
    p_in_region_r4: assert property (@(posedge clk) disable iff (rst)
        status.wip |-> ((mem_addr & ~rmask_q) == base_q));

    // R7: a write is followed by a read-back cycle, never a second write
    p_write_then_verify_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !rst_req) |=> (st_q == ST_VERIFY) && !mem_we);

    // R8: the error flag only rises as the operation ends
    p_err_ends_op_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(status.err) |-> !status.wip && !status.sus);

    // R9: while parked the block is not busy and does not write
    p_parked_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        status.sus |-> !status.wip && !mem_we);

    // R11: command reset empties every status flag on the next cycle
    p_cmd_reset_r11: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !status.wip && !status.sus && !status.wel);

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int PAGE_W  = 8,
    parameter int SECT_W  = 12,
    parameter int B32_W   = 15,
    parameter int B64_W   = 16,
    parameter int T_PGM   = 64,
    parameter int T_ERS   = 256,
    parameter int MAX_TRY = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              dat_valid,
    input  logic [7:0]        dat_byte,
    input  logic              dat_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              st_wip,
    output logic              st_wel,
    output logic              st_sus,
    output logic              st_err
);
    localparam int T_MAX = (T_PGM > T_ERS) ? T_PGM : T_ERS;
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic              buf_start, buf_push, buf_has;
    logic [PAGE_W-1:0] buf_off, buf_idx;
    logic [7:0]        buf_byte;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;
    status_t           status;

    flash_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .start     (buf_start),
        .start_off (buf_off),
        .push      (buf_push),
        .push_byte (dat_byte),
        .rd_idx    (buf_idx),
        .rd_byte   (buf_byte),
        .rd_has    (buf_has)
    );

    flash_step_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    flash_seq_fsm #(
        .ADDR_W (ADDR_W), .PAGE_W (PAGE_W), .SECT_W (SECT_W),
        .B32_W  (B32_W),  .B64_W  (B64_W),  .T_PGM  (T_PGM),
        .T_ERS  (T_ERS),  .MAX_TRY(MAX_TRY), .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .dat_valid (dat_valid),
        .dat_last  (dat_last),
        .buf_start (buf_start),
        .buf_off   (buf_off),
        .buf_push  (buf_push),
        .buf_idx   (buf_idx),
        .buf_byte  (buf_byte),
        .buf_has   (buf_has),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_zero  (tmr_zero),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .status    (status)
    );

    assign st_wip = status.wip;
    assign st_wel = status.wel;
    assign st_sus = status.sus;
    assign st_err = status.err;

endmodule

// File: tb/tb_flash_pe_seq.sv
module tb_flash_pe_seq;
    localparam int AW = 10, PW = 4, SW = 6, B32 = 7, B64 = 8;
    localparam int TP = 3, TE = 4, MT = 3;
    localparam int NBYTE = 1 << AW;

    logic          clk = 0, rst = 1;
    logic          cmd_valid = 0, dat_valid = 0, dat_last = 0;
    logic [3:0]    cmd_op = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic [7:0]    dat_byte = 0;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [7:0]    mem_wdata, mem_rdata;
    logic          st_wip, st_wel, st_sus, st_err;

    logic [7:0] mem  [NBYTE];
    logic [7:0] refm [NBYTE];

    int checks = 0, fails = 0;
    int cyc = 0, we_cnt = 0, prev_cyc = 0, gap_n = 0, gap_bad = 0, gap_exp = 0;
    bit have_prev = 0, done = 0;
    int stuck_addr = -1, stuck_left = 0;

    always #10 clk = ~clk;

    flash_pe_seq #(.ADDR_W(AW), .PAGE_W(PW), .SECT_W(SW), .B32_W(B32), .B64_W(B64),
                   .T_PGM(TP), .T_ERS(TE), .MAX_TRY(MT)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_last(dat_last),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .st_wip(st_wip), .st_wel(st_wel), .st_sus(st_sus), .st_err(st_err));

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (mem_we) begin
            we_cnt = we_cnt + 1;
            if (have_prev) begin
                gap_n = gap_n + 1;
                if (cyc - prev_cyc != gap_exp) gap_bad = gap_bad + 1;
            end
            prev_cyc  = cyc;
            have_prev = 1;
            if (int'(mem_addr) == stuck_addr && stuck_left > 0) stuck_left = stuck_left - 1;
            else mem[mem_addr] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_cmd(input int op, input int addr);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 4'(op); cmd_addr = AW'(addr);
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && st_wip; i++) @(negedge clk);
    endtask

    task automatic fill(input int seed);
        @(negedge clk);
        for (int i = 0; i < NBYTE; i++) begin
            mem[i]  = 8'((i * 13 + seed) & 255);
            refm[i] = mem[i];
        end
    endtask

    task automatic ref_erase(input int addr, input int w);
        int base;
        base = addr & ~((1 << w) - 1);
        for (int i = 0; i < (1 << w); i++) refm[base + i] = 8'hFF;
    endtask

    task automatic cmp_mem(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < NBYTE; i++) if (mem[i] !== refm[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic erase(input int op, input int addr, input int w, input string req);
        do_cmd(1, 0);
        do_cmd(op, addr);
        wait_done();
        ref_erase(addr, w);
        @(negedge clk);
        cmp_mem(req);
    endtask

    // streams n bytes (value seed + 37*k) and applies the page model to refm
    task automatic prog(input int addr, input int n, input int seed);
        logic [7:0] pb [1 << PW];
        bit         pm [1 << PW];
        int         off, page;
        for (int j = 0; j < (1 << PW); j++) pm[j] = 0;
        off  = addr & ((1 << PW) - 1);
        page = addr & ~((1 << PW) - 1);
        do_cmd(1, 0);
        do_cmd(3, addr);
        for (int k = 0; k < n; k++) begin
            dat_valid = 1; dat_byte = 8'((seed + 37 * k) & 255); dat_last = (k == n - 1);
            pb[off] = dat_byte; pm[off] = 1;
            off = (off + 1) & ((1 << PW) - 1);
            @(negedge clk);
        end
        dat_valid = 0; dat_last = 0;
        wait_done();
        for (int j = 0; j < (1 << PW); j++) if (pm[j]) refm[page + j] = refm[page + j] & pb[j];
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!st_wip && !st_wel && !st_sus && !st_err, "R1 reset status",
            {st_wip, st_wel, st_sus, st_err}, 0);
        chk(we_cnt == 0, "R1 no write in reset", we_cnt, 0);
        do_cmd(1, 0);
        chk(st_wel == 1, "R1 write enable", st_wel, 1);
        do_cmd(2, 0);
        chk(st_wel == 0, "R1 write disable", st_wel, 0);
    endtask

    task automatic t_no_wel();
        int c;
        fill(3);
        c = we_cnt;
        do_cmd(4, 'h40);
        chk(st_wip == 0, "R2 busy stays low", st_wip, 0);
        repeat (20) @(negedge clk);
        chk(we_cnt == c, "R2 no write without latch", we_cnt, c);
        cmp_mem("R2 array unchanged");
    endtask

    task automatic t_sector();
        int c;
        fill(7);
        c = we_cnt; have_prev = 0; gap_n = 0; gap_bad = 0; gap_exp = TE + 2;
        do_cmd(1, 0);
        do_cmd(4, 'h45);
        chk(st_wip == 1, "R3 busy after accept", st_wip, 1);
        wait_done();
        chk(st_wel == 0, "R3 latch cleared at end", st_wel, 0);
        chk(we_cnt - c == (1 << SW), "R4 sector write count", we_cnt - c, 1 << SW);
        chk(gap_bad == 0 && gap_n == (1 << SW) - 1, "R7 write spacing", gap_bad, 0);
        ref_erase('h45, SW);
        @(negedge clk);
        cmp_mem("R4 sector erase");
    endtask

    task automatic t_blocks();
        fill(9);
        erase(5, 'h1A3, B32, "R4 32K-class erase");
        erase(6, 'h2F0, B64, "R4 64K-class erase");
        erase(7, 'h155, AW, "R4 chip erase");
    endtask

    task automatic t_program();
        fill(21);
        prog('h123, 5, 'h5A);
        cmp_mem("R5 program AND");
        prog('h123, 5, 'hC3);
        cmp_mem("R5 second program ANDs");
        chk(st_wel == 0, "R3 latch cleared after program", st_wel, 0);
    endtask

    task automatic t_wrap();
        fill(33);
        erase(4, 'h100, SW, "R4 erase before wrap");
        prog('h13E, 4, 'h11);
        cmp_mem("R6 wrap inside page");
        prog('h150, 18, 'h29);
        cmp_mem("R6 later byte wins");
    endtask

    task automatic t_retry();
        int c;
        fill(5);
        c = we_cnt; stuck_addr = 'h205; stuck_left = 1;
        erase(4, 'h200, SW, "R8 retry recovers");
        chk(we_cnt - c == (1 << SW) + 1, "R8 one extra write", we_cnt - c, (1 << SW) + 1);
        chk(st_err == 0, "R8 no error after recovery", st_err, 0);
        fill(5);
        c = we_cnt; stuck_left = 10;
        do_cmd(1, 0);
        do_cmd(4, 'h200);
        wait_done();
        chk(st_err == 1, "R8 error after max tries", st_err, 1);
        chk(we_cnt - c == 5 + MT, "R8 writes before giving up", we_cnt - c, 5 + MT);
        for (int i = 0; i < 5; i++) refm['h200 + i] = 8'hFF;
        cmp_mem("R8 partial contents");
        stuck_addr = -1; stuck_left = 0;
        erase(4, 'h000, SW, "R8 next op");
        chk(st_err == 0, "R8 error cleared by next op", st_err, 0);
    endtask

    task automatic t_suspend();
        int c;
        int c0;
        fill(17);
        c0 = we_cnt;
        do_cmd(1, 0);
        do_cmd(5, 'h80);
        repeat (100) @(negedge clk);
        do_cmd(8, 0);
        chk(st_sus == 1 && st_wip == 0, "R9 parked status", {st_sus, st_wip}, 2);
        c = we_cnt;
        do_cmd(4, 'h300);
        repeat (40) @(negedge clk);
        chk(we_cnt == c, "R9 no writes while parked", we_cnt, c);
        chk(st_sus == 1, "R12 erase ignored while parked", st_sus, 1);
        do_cmd(9, 0);
        chk(st_wip == 1 && st_sus == 0, "R10 resume restores busy", {st_wip, st_sus}, 2);
        wait_done();
        ref_erase('h80, B32);
        @(negedge clk);
        cmp_mem("R10 resumed result");
        chk(we_cnt - c0 <= (1 << B32) + 1 && we_cnt - c0 >= (1 << B32),
            "R10 write total", we_cnt - c0, 1 << B32);
    endtask

    task automatic t_busy_ignore();
        fill(41);
        do_cmd(1, 0);
        do_cmd(4, 'h0C0);
        do_cmd(7, 0);
        wait_done();
        ref_erase('h0C0, SW);
        @(negedge clk);
        cmp_mem("R12 chip erase ignored while busy");
    endtask

    task automatic t_cmd_reset();
        int c;
        fill(55);
        do_cmd(1, 0);
        do_cmd(6, 'h300);
        repeat (40) @(negedge clk);
        do_cmd(10, 0);
        chk(!st_wip && !st_sus && !st_wel, "R11 abort clears status",
            {st_wip, st_sus, st_wel}, 0);
        c = we_cnt;
        repeat (30) @(negedge clk);
        chk(we_cnt == c, "R11 writes stop", we_cnt, c);
        do_cmd(1, 0);
        do_cmd(4, 'h340);
        repeat (20) @(negedge clk);
        do_cmd(8, 0);
        do_cmd(10, 0);
        chk(!st_sus && !st_wip && !st_wel, "R11 abort from parked",
            {st_sus, st_wip, st_wel}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_no_wel();
        t_sector();
        t_blocks();
        t_program();
        t_wrap();
        t_retry();
        t_suspend();
        t_busy_ignore();
        t_cmd_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule